// File: doc/BRIEF.md
# Package Activity Residency Monitor

This block observes one busy/idle flag per core of a multi-core package and measures how many clock ticks the package spends in each activity state over fixed observation windows. On every enabled clock it sorts the package into one of three classes: every core busy, every core idle, or a mix of busy and idle cores. It also keeps a separate tick count for each of the 2^N exact per-core busy patterns, so logic downstream can tell where the idle cores sit and whether their idle periods overlap.

The window length is a parameter counted in clock ticks; at 50 MHz a 500 us slot is 25000 ticks. On the last tick of each window, all class and pattern counts, including that last tick, are copied into held snapshot outputs. A one-cycle valid strobe marks each new snapshot, and counting carries on into the next window without losing a tick. A consumer such as a predictor or a power-state controller takes the snapshot on the strobe.

Top module: `resmon_top`

## Requirements
- R1: Bit i of `core_busy` high means core i is busy. A tick counts as all-busy when every bit is 1, as all-idle when every bit is 0, and as partial otherwise. `snap_all_busy`, `snap_all_idle` and `snap_partial` report the per-class totals of the last completed window.
- R2: Pattern counter k counts the ticks on which `core_busy` equals k. Its snapshot appears in `snap_combo[k*CW +: CW]`, where CW = $clog2(WINDOW_TICKS+1).
- R3: Each enabled tick increments exactly one class counter and exactly one pattern counter.
- R4: A window is WINDOW_TICKS enabled ticks long. After the edge that ends a window, `snap_valid` is high for exactly one cycle, and the snapshot includes the final tick.
- R5: The tick after a window's final tick is the first tick of the next window. No tick is lost or counted twice at the boundary.
- R6: In every snapshot, the three class totals sum to WINDOW_TICKS, and so do the pattern totals.
- R7: The partial total equals the sum of all pattern totals except those for pattern 0 and the all-ones pattern. The all-busy total equals the all-ones pattern total, and the all-idle total equals the pattern-0 total.
- R8: While `enable` is low, the counters and the window timer hold their values and no snapshot is produced. The ticks already counted resume when `enable` returns high.
- R9: Reset (`rst_n` low, asynchronous) clears every counter, the window timer and all snapshot outputs, and drives `snap_valid` low.
- R10: Between strobes the snapshot outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Counts the current tick when high; freezes all state when low |
| core_busy | input | NUM_CORES | Per-core busy flags, synchronous to clk |
| snap_valid | output | 1 | One-cycle strobe marking a new snapshot |
| snap_all_busy | output | CW | All-busy ticks in the last window |
| snap_all_idle | output | CW | All-idle ticks in the last window |
| snap_partial | output | CW | Partial-idle ticks in the last window |
| snap_combo | output | 2^NUM_CORES * CW | Per-pattern tick counts, field k for pattern k |

## Verification
Two things happen on the last tick of a window: that tick's own increment, and the transfer of the running counts into the snapshot together with the counter clear. The bench provokes this collision by making the final tick's busy pattern differ from the rest of the window. A snapshot that left the final tick out would then show a pattern total one short, and a clear that came too late would leave one tick too many in the next window. Disabled cycles are also placed right before a window's final tick, to show that the collision happens only on an enabled tick. Each snapshot is judged against per-pattern totals that the bench keeps itself, with the class totals derived from them.

// File: rtl/resmon_pkg.sv
package resmon_pkg;

  typedef enum logic [1:0] {
    CLS_ALL_IDLE = 2'd0,
    CLS_PARTIAL  = 2'd1,
    CLS_ALL_BUSY = 2'd2
  } act_class_e;

  localparam int NUM_CLASSES = 3;

endpackage

// File: rtl/resmon_classifier.sv
module resmon_classifier
  import resmon_pkg::*;
#(
  parameter int NUM_CORES = 2
) (
  input  logic [NUM_CORES-1:0]        core_busy,
  output logic [NUM_CLASSES-1:0]      class_hot,
  output logic [(1<<NUM_CORES)-1:0]   combo_hot
);

  function automatic act_class_e classify(input logic [NUM_CORES-1:0] b);
    if (&b)       return CLS_ALL_BUSY;
    else if (~|b) return CLS_ALL_IDLE;
    else          return CLS_PARTIAL;
  endfunction

  act_class_e cls;

  always_comb begin
    cls            = classify(core_busy);
    class_hot      = '0;
    class_hot[cls] = 1'b1;
    combo_hot      = '0;
    combo_hot[core_busy] = 1'b1;
  end

endmodule

// File: rtl/resmon_window_timer.sv
module resmon_window_timer #(
  parameter int WINDOW_TICKS = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic win_last
);

  localparam int TW = (WINDOW_TICKS > 2) ? $clog2(WINDOW_TICKS) : 1;
  localparam logic [TW-1:0] LAST_IDX = TW'(WINDOW_TICKS - 1);

  logic [TW-1:0] tick_q;

  function automatic logic [TW-1:0] advance(input logic [TW-1:0] t);
    return (t == LAST_IDX) ? '0 : t + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tick_q <= '0;
    else if (enable) tick_q <= advance(tick_q);
  end

  assign win_last = enable && (tick_q == LAST_IDX);

endmodule

// File: rtl/resmon_counter_bank.sv
module resmon_counter_bank #(
  parameter int NUM = 3,
  parameter int CW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              win_last,
  input  logic [NUM-1:0]    inc,
  output logic [NUM*CW-1:0] snap
);

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] c, input logic hit);
    return c + CW'(hit);
  endfunction

  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    logic [CW-1:0] run_q;
    logic [CW-1:0] snap_q;
    logic [CW-1:0] run_nxt;

    assign run_nxt = bump(run_q, inc[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q  <= '0;
        snap_q <= '0;
      end else if (enable) begin
        if (win_last) begin
          snap_q <= run_nxt;
          run_q  <= '0;
        end else begin
          run_q  <= run_nxt;
        end
      end
    end

    assign snap[g*CW +: CW] = snap_q;
  end

endmodule

// File: rtl/resmon_top.sv
module resmon_top
  import resmon_pkg::*;
#(
  parameter int NUM_CORES    = 2,
  parameter int WINDOW_TICKS = 25000,
  parameter int CW           = $clog2(WINDOW_TICKS + 1),
  parameter int NCOMBO       = 1 << NUM_CORES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [NUM_CORES-1:0] core_busy,
  output logic                 snap_valid,
  output logic [CW-1:0]        snap_all_busy,
  output logic [CW-1:0]        snap_all_idle,
  output logic [CW-1:0]        snap_partial,
  output logic [NCOMBO*CW-1:0] snap_combo
);

  logic [NUM_CLASSES-1:0]    class_hot;
  logic [NCOMBO-1:0]         combo_hot;
  logic                      win_last;
  logic [NUM_CLASSES*CW-1:0] class_snap;
  logic                      valid_q;

  resmon_classifier #(.NUM_CORES(NUM_CORES)) u_cls (
    .core_busy (core_busy),
    .class_hot (class_hot),
    .combo_hot (combo_hot)
  );

  resmon_window_timer #(.WINDOW_TICKS(WINDOW_TICKS)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .win_last (win_last)
  );

  resmon_counter_bank #(.NUM(NUM_CLASSES), .CW(CW)) u_class_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .win_last (win_last),
    .inc      (class_hot),
    .snap     (class_snap)
  );

  resmon_counter_bank #(.NUM(NCOMBO), .CW(CW)) u_combo_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .win_last (win_last),
    .inc      (combo_hot),
    .snap     (snap_combo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= win_last;
  end

  assign snap_valid    = valid_q;
  assign snap_all_busy = class_snap[int'(CLS_ALL_BUSY)*CW +: CW];
  assign snap_all_idle = class_snap[int'(CLS_ALL_IDLE)*CW +: CW];
  assign snap_partial  = class_snap[int'(CLS_PARTIAL)*CW +: CW];

endmodule

// File: rtl/resmon_checker.sv
module resmon_checker #(
  parameter int NUM_CORES    = 2,
  parameter int WINDOW_TICKS = 25000,
  parameter int CW           = 15,
  parameter int NCOMBO       = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 enable,
  input logic [2:0]           class_hot,
  input logic [NCOMBO-1:0]    combo_hot,
  input logic                 snap_valid,
  input logic [CW-1:0]        snap_all_busy,
  input logic [CW-1:0]        snap_all_idle,
  input logic [CW-1:0]        snap_partial,
  input logic [NCOMBO*CW-1:0] snap_combo
);

  function automatic int combo_total(input logic [NCOMBO*CW-1:0] v);
    int s = 0;
    for (int k = 0; k < NCOMBO; k++) s += int'(v[k*CW +: CW]);
    return s;
  endfunction

  function automatic int mixed_total(input logic [NCOMBO*CW-1:0] v);
    int s = 0;
    for (int k = 1; k < NCOMBO - 1; k++) s += int'(v[k*CW +: CW]);
    return s;
  endfunction

  // R3: one class and one pattern counter per tick
  a_r3_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> $countones(class_hot) == 1);
  a_r3_one_combo: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> $countones(combo_hot) == 1);

  // R4: the strobe lasts one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    snap_valid |=> !snap_valid);

  // R6: totals fill the window
  a_r6_class_sum: assert property (@(posedge clk) disable iff (!rst_n)
    snap_valid |-> (int'(snap_all_busy) + int'(snap_all_idle) + int'(snap_partial)) == WINDOW_TICKS);
  a_r6_combo_sum: assert property (@(posedge clk) disable iff (!rst_n)
    snap_valid |-> combo_total(snap_combo) == WINDOW_TICKS);

  // R7: class and pattern views agree
  a_r7_partial_match: assert property (@(posedge clk) disable iff (!rst_n)
    snap_valid |-> int'(snap_partial) == mixed_total(snap_combo));
  a_r7_ends_match: assert property (@(posedge clk) disable iff (!rst_n)
    snap_valid |-> (snap_all_idle == snap_combo[0 +: CW]) &&
                   (snap_all_busy == snap_combo[(NCOMBO-1)*CW +: CW]));

  // R8: no snapshot while frozen
  a_r8_no_strobe_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !snap_valid);

  // R10: snapshot held between strobes
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_valid |-> ($stable(snap_combo) && $stable(snap_partial) &&
                     $stable(snap_all_busy) && $stable(snap_all_idle)));

endmodule

bind resmon_top resmon_checker #(
  .NUM_CORES(NUM_CORES), .WINDOW_TICKS(WINDOW_TICKS), .CW(CW), .NCOMBO(NCOMBO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .class_hot(class_hot), .combo_hot(combo_hot),
  .snap_valid(snap_valid), .snap_all_busy(snap_all_busy),
  .snap_all_idle(snap_all_idle), .snap_partial(snap_partial),
  .snap_combo(snap_combo)
);

// File: tb/sim_resmon_top.sv
`timescale 1ns/1ps
module sim_resmon_top;
  localparam int NC  = 2;
  localparam int W   = 6;
  localparam int CW  = $clog2(W + 1);
  localparam int NCB = 1 << NC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [NC-1:0] core_busy = '0;
  logic snap_valid;
  logic [CW-1:0] snap_all_busy, snap_all_idle, snap_partial;
  logic [NCB*CW-1:0] snap_combo;

  int tests = 0, fails = 0;
  int exp_cnt[NCB];
  int held[NCB];
  int wcount = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  resmon_top #(.NUM_CORES(NC), .WINDOW_TICKS(W)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .core_busy(core_busy),
    .snap_valid(snap_valid), .snap_all_busy(snap_all_busy),
    .snap_all_idle(snap_all_idle), .snap_partial(snap_partial),
    .snap_combo(snap_combo)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_snapshot();
    for (int k = 0; k < NCB; k++)
      check("R2 pattern count", int'(snap_combo[k*CW +: CW]), held[k]);
    check("R1 all-busy", int'(snap_all_busy), held[NCB-1]);
    check("R1 all-idle", int'(snap_all_idle), held[0]);
    check("R7 partial", int'(snap_partial), held[1] + held[2]);
  endtask

  task automatic clear_model();
    for (int k = 0; k < NCB; k++) exp_cnt[k] = 0;
    wcount = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    clear_model();
    for (int k = 0; k < NCB; k++) held[k] = 0;
    check("R9 valid in reset", int'(snap_valid), 0);
    check_snapshot();
    rst_n = 1'b1;
  endtask

  task automatic tick(input logic [NC-1:0] b, input logic e);
    core_busy = b;
    enable    = e;
    @(posedge clk);
    @(negedge clk);
    if (e) begin
      exp_cnt[b]++;
      wcount++;
    end
    if (e && wcount == W) begin
      held = exp_cnt;
      clear_model();
      check("R4 R5 strobe", int'(snap_valid), 1);
      check("R3 R6 class sum", int'(snap_all_busy) + int'(snap_all_idle) + int'(snap_partial), W);
    end else begin
      check(e ? "R4 no strobe mid-window" : "R8 no strobe frozen", int'(snap_valid), 0);
    end
    check_snapshot();  // R10 holds between strobes
  endtask

  initial begin
    do_reset();
    // sweep every pattern, rotating so window boundaries land on each pattern
    for (int w = 0; w < 4; w++)
      for (int t = 0; t < W; t++) tick(NC'((t + w) % NCB), 1'b1);
    // uniform windows: all busy then all idle (R1 edges)
    for (int t = 0; t < W; t++) tick(2'b11, 1'b1);
    for (int t = 0; t < W; t++) tick(2'b00, 1'b1);
    // final tick differs from rest of window (R4, R5 collision)
    for (int w = 0; w < 3; w++) begin
      for (int t = 0; t < W - 1; t++) tick(2'b11, 1'b1);
      tick(NC'(w), 1'b1);
    end
    // frozen cycles mid-window and just before the final tick (R8)
    tick(2'b01, 1'b1);
    tick(2'b10, 1'b0);
    tick(2'b10, 1'b1);
    for (int t = 0; t < 3; t++) tick(2'b00, 1'b1);
    for (int t = 0; t < 4; t++) tick(2'b11, 1'b0);
    tick(2'b01, 1'b1);
    // frozen on the very cycle a window would close
    for (int t = 0; t < W - 1; t++) tick(2'b10, 1'b1);
    tick(2'b00, 1'b0);
    tick(2'b00, 1'b0);
    tick(2'b11, 1'b1);
    // reset mid-window, then a fresh window (R9)
    for (int t = 0; t < 3; t++) tick(2'b01, 1'b1);
    do_reset();
    for (int t = 0; t < W; t++) tick(NC'(t % 3), 1'b1);
    for (int t = 0; t < W; t++) tick(NC'((t * 3) % NCB), 1'b1);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule